// File: doc/BRIEF.md
# Video Timing-Reference Guard

This block sits on a 10-bit video word stream and looks for timing reference sequences. A sequence is a run of three preamble words followed by a flag word that carries the field, vertical-blanking and horizontal-position bits and four protection bits. For every sequence found, the block checks the protection bits against the three flag bits. When position checking is on, it also checks that the sequence arrived in the same cycle in which an external line/sample counter said one was due. Start-of-active-video and end-of-active-video problems are kept apart in two sticky status bits.

The preamble detector accepts both the full 10-bit preamble and the form that comes from 8-bit equipment, where only the upper eight bits of each preamble word are defined. A parameter can switch it to strict 10-bit matching. The external counter supplies one strobe per sequence class, asserted in the cycle the flag word is expected. An enable input decides whether those strobes are consulted at all. Errors found by the protection check are always reported.

Top module: `trs_guard`

## Requirements
- R1: A sequence is recognised when a word whose bits 9..2 are all ones is followed by two words whose bits 9..2 are all zero. The next word is taken as the flag word. With ACCEPT_8BIT=1 bits 1..0 of the preamble words are ignored. With ACCEPT_8BIT=0 the preamble must be exactly 3FFh, 000h, 000h. A repeated all-ones word restarts the preamble.
- R2: The flag word carries a marker in bit 9, F in bit 8, V in bit 7, H in bit 6 and protection bits P3..P0 in bits 5..2. Bits 1..0 are ignored. H=1 classes the sequence as end-of-active-video and H=0 as start-of-active-video.
- R3: If the marker bit is 0, or P3..P0 differ from {V^H, F^H, F^V, F^V^H}, the status bit of the received class is set, whatever pos_check_en is.
- R4: With pos_check_en=1, a decoded sequence whose class strobe is low in its flag-word cycle sets that class's status bit.
- R5: With pos_check_en=1, a class strobe that is high in a cycle with no flag word of that class sets that class's status bit.
- R6: With pos_check_en=0, the strobes and any position mismatch have no effect on the status bits.
- R7: A status bit is set at the clock edge that ends the offending cycle and stays set until cleared.
- R8: status_clr=1 clears both status bits at the next edge. A new error in that same cycle wins over the clear.
- R9: After reset both status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_word | input | 10 | Incoming video word, one per cycle |
| pos_check_en | input | 1 | Enables comparison with the expected-position strobes |
| sav_expected | input | 1 | Counter says a start-of-active-video flag word is due this cycle |
| eav_expected | input | 1 | Counter says an end-of-active-video flag word is due this cycle |
| status_clr | input | 1 | Clears both status bits |
| sav_err | output | 1 | Sticky start-of-active-video error |
| eav_err | output | 1 | Sticky end-of-active-video error |

## Verification
The bench builds the main instance with the defaults WORD_W=10 and ACCEPT_8BIT=1. With these values, preambles with stray low bits such as 3FCh/003h and flag words with junk in bits 1..0 can be exercised. A second instance built with ACCEPT_8BIT=0 sees the same stimulus. On that instance a relaxed preamble must go unrecognised and so show up as a missing sequence, while an exact 10-bit preamble passes on both.

// File: rtl/trs_guard_pkg.sv
package trs_guard_pkg;

    // Preamble tracking states
    typedef enum logic [1:0] {
        ST_SEEK   = 2'd0,   // no preamble word seen
        ST_ONES   = 2'd1,   // all-ones word seen
        ST_ZERO_A = 2'd2,   // first zero word seen
        ST_ZERO_B = 2'd3    // second zero word seen; current word is the flag word
    } trs_seek_e;

    localparam int N_CLASS  = 2;
    localparam int CLS_SAV  = 0;
    localparam int CLS_EAV  = 1;

    // Protection bits P3..P0 derived from F, V, H
    function automatic logic [3:0] trs_prot(input logic f, input logic v, input logic h);
        return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/trs_preamble_fsm.sv
module trs_preamble_fsm
    import trs_guard_pkg::*;
#(
    parameter int WORD_W      = 10,
    parameter bit ACCEPT_8BIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word,
    output logic              xyz_cycle
);

    localparam int SLACK = ACCEPT_8BIT ? 2 : 0;
    localparam logic [WORD_W-1:0] CMP_MASK = {{(WORD_W-SLACK){1'b1}}, {SLACK{1'b0}}};

    logic      is_ones;
    logic      is_zero;
    trs_seek_e state_q;
    trs_seek_e state_d;

    assign is_ones = ((word & CMP_MASK) == CMP_MASK);
    assign is_zero = ((word & CMP_MASK) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEEK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = ST_SEEK;
        unique case (state_q)
            ST_SEEK: begin
                state_d = is_ones ? ST_ONES : ST_SEEK;
            end
            ST_ONES: begin
                if (is_ones)      state_d = ST_ONES;
                else if (is_zero) state_d = ST_ZERO_A;
                else              state_d = ST_SEEK;
            end
            ST_ZERO_A: begin
                if (is_zero)      state_d = ST_ZERO_B;
                else if (is_ones) state_d = ST_ONES;
                else              state_d = ST_SEEK;
            end
            ST_ZERO_B: begin
                state_d = is_ones ? ST_ONES : ST_SEEK;
            end
            default: state_d = ST_SEEK;
        endcase
    end

    always_comb begin
        xyz_cycle = (state_q == ST_ZERO_B);
    end

endmodule

// File: rtl/trs_xyz_check.sv
module trs_xyz_check
    import trs_guard_pkg::*;
(
    input  logic [7:0] flag_bits,   // marker, F, V, H, P3..P0
    output logic       is_eav,
    output logic       prot_bad
);

    logic       marker;
    logic       f_bit;
    logic       v_bit;
    logic       h_bit;
    logic [3:0] p_rx;

    always_comb begin
        {marker, f_bit, v_bit, h_bit, p_rx} = flag_bits;
        is_eav   = h_bit;
        prot_bad = !marker || (p_rx != trs_prot(f_bit, v_bit, h_bit));
    end

endmodule

// File: rtl/trs_status_reg.sv
module trs_status_reg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] evt,
    output logic [N-1:0] flag
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag[i] <= 1'b0;
            end else if (evt[i]) begin
                flag[i] <= 1'b1;
            end else if (clr) begin
                flag[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/trs_guard.sv
module trs_guard
    import trs_guard_pkg::*;
#(
    parameter int WORD_W      = 10,
    parameter bit ACCEPT_8BIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] vid_word,
    input  logic              pos_check_en,
    input  logic              sav_expected,
    input  logic              eav_expected,
    input  logic              status_clr,
    output logic              sav_err,
    output logic              eav_err
);

    localparam int MARK_B = WORD_W - 1;
    localparam int PROT_L = WORD_W - 8;

    logic               xyz_cycle;
    logic               is_eav;
    logic               prot_bad;
    logic [N_CLASS-1:0] hit;
    logic [N_CLASS-1:0] due;
    logic [N_CLASS-1:0] evt;
    logic [N_CLASS-1:0] flags;

    trs_preamble_fsm #(
        .WORD_W      (WORD_W),
        .ACCEPT_8BIT (ACCEPT_8BIT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .word      (vid_word),
        .xyz_cycle (xyz_cycle)
    );

    trs_xyz_check u_xyz (
        .flag_bits (vid_word[MARK_B:PROT_L]),
        .is_eav    (is_eav),
        .prot_bad  (prot_bad)
    );

    always_comb begin
        hit[CLS_SAV] = xyz_cycle && !is_eav;
        hit[CLS_EAV] = xyz_cycle &&  is_eav;
        due[CLS_SAV] = sav_expected;
        due[CLS_EAV] = eav_expected;
        for (int c = 0; c < N_CLASS; c++) begin
            evt[c] = (hit[c] && prot_bad) || (pos_check_en && (hit[c] != due[c]));
        end
    end

    trs_status_reg #(.N(N_CLASS)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (status_clr),
        .evt   (evt),
        .flag  (flags)
    );

    assign sav_err = flags[CLS_SAV];
    assign eav_err = flags[CLS_EAV];

endmodule

// File: rtl/trs_guard_chk.sv
module trs_guard_chk #(
    parameter int WORD_W      = 10,
    parameter bit ACCEPT_8BIT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] vid_word,
    input logic              pos_check_en,
    input logic              sav_expected,
    input logic              eav_expected,
    input logic              status_clr,
    input logic              sav_err,
    input logic              eav_err,
    input logic              xyz_cycle
);

    localparam int SLACK = ACCEPT_8BIT ? 2 : 0;
    localparam logic [WORD_W-1:0] M = {{(WORD_W-SLACK){1'b1}}, {SLACK{1'b0}}};
    localparam int B_MK = WORD_W - 1;
    localparam int B_F  = WORD_W - 2;
    localparam int B_V  = WORD_W - 3;
    localparam int B_H  = WORD_W - 4;
    localparam int B_PH = WORD_W - 5;
    localparam int B_PL = WORD_W - 8;

    logic       w_ones;
    logic       w_zero;
    logic       w_h;
    logic [3:0] p_want;
    logic       w_bad;

    always_comb begin
        w_ones = ((vid_word & M) == M);
        w_zero = ((vid_word & M) == '0);
        w_h    = vid_word[B_H];
        p_want = {vid_word[B_V] ^ vid_word[B_H], vid_word[B_F] ^ vid_word[B_H],
                  vid_word[B_F] ^ vid_word[B_V],
                  vid_word[B_F] ^ vid_word[B_V] ^ vid_word[B_H]};
        w_bad  = !vid_word[B_MK] || (vid_word[B_PH:B_PL] != p_want);
    end

    AST_PREAMBLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        xyz_cycle |-> $past(w_zero, 1) && $past(w_zero, 2) && $past(w_ones, 3)); // R1
    AST_PROT_SAV: assert property (@(posedge clk) disable iff (!rst_n)
        xyz_cycle && w_bad && !w_h |=> sav_err); // R3
    AST_PROT_EAV: assert property (@(posedge clk) disable iff (!rst_n)
        xyz_cycle && w_bad && w_h |=> eav_err); // R3
    AST_UNEXPECTED_EAV: assert property (@(posedge clk) disable iff (!rst_n)
        pos_check_en && xyz_cycle && w_h && !eav_expected |=> eav_err); // R4
    AST_MISSING_SAV: assert property (@(posedge clk) disable iff (!rst_n)
        pos_check_en && sav_expected && !(xyz_cycle && !w_h) |=> sav_err); // R5
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_check_en && !xyz_cycle && !sav_err && !eav_err |=> !sav_err && !eav_err); // R6
    AST_SAV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sav_err && !status_clr |=> sav_err); // R7
    AST_EAV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        eav_err && !status_clr |=> eav_err); // R7
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr && !xyz_cycle && !(pos_check_en && (sav_expected || eav_expected))
        |=> !sav_err && !eav_err); // R8
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |-> !sav_err && !eav_err); // R9

endmodule

bind trs_guard trs_guard_chk #(
    .WORD_W      (WORD_W),
    .ACCEPT_8BIT (ACCEPT_8BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vid_word     (vid_word),
    .pos_check_en (pos_check_en),
    .sav_expected (sav_expected),
    .eav_expected (eav_expected),
    .status_clr   (status_clr),
    .sav_err      (sav_err),
    .eav_err      (eav_err),
    .xyz_cycle    (xyz_cycle)
);

// File: tb/tb_trs_guard.sv
module tb_trs_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] vid_word = 10'h040;
    logic       pos_check_en = 1'b0;
    logic       sav_expected = 1'b0;
    logic       eav_expected = 1'b0;
    logic       status_clr = 1'b0;
    logic       sav_err, eav_err;
    logic       sav_err_s, eav_err_s;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [9:0] IDLE = 10'h040;

    always #2 clk = ~clk;

    trs_guard dut (
        .clk(clk), .rst_n(rst_n), .vid_word(vid_word), .pos_check_en(pos_check_en),
        .sav_expected(sav_expected), .eav_expected(eav_expected), .status_clr(status_clr),
        .sav_err(sav_err), .eav_err(eav_err)
    );

    trs_guard #(.ACCEPT_8BIT(1'b0)) dut_strict (
        .clk(clk), .rst_n(rst_n), .vid_word(vid_word), .pos_check_en(pos_check_en),
        .sav_expected(sav_expected), .eav_expected(eav_expected), .status_clr(status_clr),
        .sav_err(sav_err_s), .eav_err(eav_err_s)
    );

    // {req, ones word, zero word, flag word, en, sav_due, eav_due, exp_sav, exp_eav}
    localparam int NV = 13;
    localparam logic [38:0] VECS [NV] = '{
        {4'd2, 10'h3FF, 10'h000, 10'h200, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 SAV on time
        {4'd2, 10'h3FF, 10'h000, 10'h274, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 EAV on time
        {4'd1, 10'h3FC, 10'h003, 10'h2AE, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 8-bit form
        {4'd1, 10'h3FD, 10'h001, 10'h368, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R1 8-bit form EAV
        {4'd3, 10'h3FF, 10'h000, 10'h318, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 bad P, SAV
        {4'd3, 10'h3FF, 10'h000, 10'h3D4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 bad P, EAV
        {4'd4, 10'h3FF, 10'h000, 10'h200, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 SAV not due
        {4'd6, 10'h3FF, 10'h000, 10'h200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 same, check off
        {4'd4, 10'h3FF, 10'h000, 10'h274, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 EAV where SAV due
        {4'd3, 10'h3FF, 10'h000, 10'h074, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 marker bit clear
        {4'd2, 10'h3FF, 10'h000, 10'h3B0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R2 F=1 V=1 SAV
        {4'd2, 10'h3FE, 10'h002, 10'h2D8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 V=1 EAV
        {4'd5, 10'h3FF, 10'h010, 10'h200, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}  // R5 broken preamble
    };

    task automatic chk(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic run_seq(input logic [9:0] o, input logic [9:0] z, input logic [9:0] x,
                           input logic en, input logic sd, input logic ed);
        @(negedge clk); vid_word = IDLE; status_clr = 1'b1; pos_check_en = en;
                        sav_expected = 1'b0; eav_expected = 1'b0;
        @(negedge clk); status_clr = 1'b0; vid_word = o;
        @(negedge clk); vid_word = z;
        @(negedge clk); vid_word = z;
        @(negedge clk); vid_word = x; sav_expected = sd; eav_expected = ed;
        @(negedge clk); vid_word = IDLE; sav_expected = 1'b0; eav_expected = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sav_err, 1'b0, "R9 sav after reset");
        chk(eav_err, 1'b0, "R9 eav after reset");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_seq(VECS[i][34:25], VECS[i][24:15], VECS[i][14:5],
                    VECS[i][4], VECS[i][3], VECS[i][2]);
            chk(sav_err, VECS[i][1], $sformatf("R%0d vec %0d sav", VECS[i][38:35], i));
            chk(eav_err, VECS[i][0], $sformatf("R%0d vec %0d eav", VECS[i][38:35], i));
        end

        // R1: strict build rejects relaxed preamble, accepts exact one
        run_seq(10'h3FC, 10'h000, 10'h200, 1'b1, 1'b1, 1'b0);
        chk(sav_err, 1'b0, "R1 relaxed preamble default build");
        chk(sav_err_s, 1'b1, "R1 relaxed preamble strict build");
        run_seq(10'h3FF, 10'h000, 10'h200, 1'b1, 1'b1, 1'b0);
        chk(sav_err_s, 1'b0, "R1 exact preamble strict build");

        // R1: repeated all-ones word restarts the preamble
        @(negedge clk); status_clr = 1'b1; pos_check_en = 1'b1;
        @(negedge clk); status_clr = 1'b0; vid_word = 10'h3FF;
        @(negedge clk); vid_word = 10'h3FF;
        @(negedge clk); vid_word = 10'h000;
        @(negedge clk); vid_word = 10'h000;
        @(negedge clk); vid_word = 10'h274; eav_expected = 1'b1;
        @(negedge clk); vid_word = IDLE; eav_expected = 1'b0;
        chk(eav_err, 1'b0, "R1 double ones then EAV");
        chk(sav_err, 1'b0, "R1 double ones sav quiet");

        // R5: EAV strobe with idle traffic
        @(negedge clk); eav_expected = 1'b1;
        @(negedge clk); eav_expected = 1'b0;
        chk(eav_err, 1'b1, "R5 missing EAV");

        // R7: stays set across idle cycles
        repeat (4) @(negedge clk);
        chk(eav_err, 1'b1, "R7 EAV flag held");

        // R6: strobe ignored with check disabled
        @(negedge clk); status_clr = 1'b1; pos_check_en = 1'b0;
        @(negedge clk); status_clr = 1'b0; sav_expected = 1'b1; eav_expected = 1'b1;
        @(negedge clk); sav_expected = 1'b0; eav_expected = 1'b0;
        chk(sav_err, 1'b0, "R6 sav strobe ignored");
        chk(eav_err, 1'b0, "R6 eav strobe ignored");

        // R8: event in the clearing cycle wins
        @(negedge clk); pos_check_en = 1'b1; sav_expected = 1'b1;
        @(negedge clk); sav_expected = 1'b0;
        chk(sav_err, 1'b1, "R5 missing SAV before clear");
        @(negedge clk); status_clr = 1'b1; sav_expected = 1'b1;
        @(negedge clk); status_clr = 1'b0; sav_expected = 1'b0;
        chk(sav_err, 1'b1, "R8 event beats clear");
        @(negedge clk); status_clr = 1'b1;
        @(negedge clk); status_clr = 1'b0;
        chk(sav_err, 1'b0, "R8 clear alone");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule